// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block makes the control decisions that keep a five-stage integer pipeline (fetch, decode, execute, memory, write-back) correct when instructions depend on each other. Each cycle it compares the source register numbers of the instructions in decode and execute with the destination numbers of the older instructions further down the pipe. It then picks where each ALU operand comes from: the register-file read captured at decode, the memory-stage latch, or the write-back-stage latch. When a load sits in execute and the instruction behind it in decode needs the loaded register, it raises a stall. The stall freezes the PC and the fetch/decode latch and puts a no-op bubble into the decode/execute latch.

The block is purely combinational. A clock and reset are present only so that its built-in checks can sample. The parameter `WB_LATE_WRITE` sets the register-file timing.

- At 0, the file writes early in the cycle and reads late, so decode already sees a value being written back.
- At 1, the write lands after the read. A decode-stage bypass select then steers the write-back value into the decode/execute operand latch in place of the stale file value.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An ALU operand select reads 2'b10 (take the memory-stage latch) when the memory-stage instruction writes a nonzero register equal to that operand's execute-stage source.
- R2: An ALU operand select reads 2'b01 (take the write-back latch) when the write-back instruction writes a nonzero register equal to the source, and the memory-stage instruction does not match.
- R3: When both latches match the same source, the select reads 2'b10, so the younger producer wins.
- R4: A select reads 2'b00 (register-file value) when no producer matches. A producer whose write-enable is low never matches, and register 0 never matches.
- R5: `stall_fetch` is 1 when the execute-stage instruction is a load with write-enable set and a nonzero destination equal to either decode-stage source. Otherwise it is 0.
- R6: `bubble_idex` equals `stall_fetch` in every cycle.
- R7: With `WB_LATE_WRITE`=0, both decode-stage bypass outputs stay 0 in every cycle.
- R8: With `WB_LATE_WRITE`=1, a decode-stage bypass output is 1 exactly when the write-back instruction writes a nonzero register equal to that decode-stage source.
- R9: An ALU operand select never reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| ex_src_a | input | REG_AW | First source register of the execute-stage instruction |
| ex_src_b | input | REG_AW | Second source register of the execute-stage instruction |
| ex_dst | input | REG_AW | Destination of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| id_src_a | input | REG_AW | First source register of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register of the decode-stage instruction |
| mem_dst | input | REG_AW | Destination held in the memory-stage latch |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_AW | Destination held in the write-back latch |
| wb_wen | input | 1 | Write-back instruction writes a register |
| alu_a_sel | output | 2 | First ALU operand source: 00 file, 01 write-back, 10 memory stage |
| alu_b_sel | output | 2 | Second ALU operand source, same encoding |
| stall_fetch | output | 1 | Hold PC and the fetch/decode latch |
| bubble_idex | output | 1 | Load a no-op into the decode/execute latch |
| id_a_take_wb | output | 1 | Steer the write-back value into the first decode/execute operand |
| id_b_take_wb | output | 1 | Steer the write-back value into the second decode/execute operand |

## Verification
Two functions can act in the same cycle. The first case is a load-use stall raised while the instruction in execute is itself receiving forwarded operands. The second, in late-write mode, is a stall raised while the decode-stage write-back bypass is active for the instruction being held. The bench builds these with small register numbers so that execute, decode, memory-stage and write-back fields collide often, and it runs one instance in each write mode. Every output of both instances is compared each cycle against a reference written as plain if-chains. Directed cases pin down both-latch priority, register 0 and low write-enable.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_AW = 5;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;

  // A producer supplies a register only if it writes and the target is not r0.
  function automatic logic producer_hits(input reg_idx_t dst, input logic wen,
                                         input reg_idx_t src);
    return wen && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_idx_t  src,
  input  reg_idx_t  mem_dst,
  input  logic      mem_wen,
  input  reg_idx_t  wb_dst,
  input  logic      wb_wen,
  output opnd_src_e sel,
  output logic      mem_match,
  output logic      wb_match
);
  assign mem_match = producer_hits(mem_dst, mem_wen, src);
  assign wb_match  = producer_hits(wb_dst, wb_wen, src);

  always_comb begin
    if (mem_match)     sel = SRC_MEM;
    else if (wb_match) sel = SRC_WB;
    else               sel = SRC_RF;
  end

  p_mem_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && mem_dst != '0 && mem_dst == src) |-> sel == SRC_MEM);
  p_wb_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && wb_dst != '0 && wb_dst == src && !mem_match) |-> sel == SRC_WB);
  p_younger_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_match && wb_match) |-> sel == SRC_MEM);
  p_r0_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> sel == SRC_RF);
  p_no_code3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_in_ex,
  input  reg_idx_t ld_dst,
  input  logic     ld_wen,
  input  reg_idx_t use_a,
  input  reg_idx_t use_b,
  output logic     hold
);
  logic hit_a, hit_b;
  assign hit_a = producer_hits(ld_dst, ld_wen, use_a);
  assign hit_b = producer_hits(ld_dst, ld_wen, use_b);
  assign hold  = ld_in_ex && (hit_a || hit_b);

  p_no_stall_wo_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_in_ex |-> !hold);
  p_no_stall_r0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dst == '0 || !ld_wen) |-> !hold);
endmodule

// File: rtl/hz_id_bypass.sv
module hz_id_bypass
  import hz_pkg::*;
#(
  parameter bit WB_LATE_WRITE = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  reg_idx_t id_src,
  input  reg_idx_t wb_dst,
  input  logic     wb_wen,
  output logic     take_wb
);
  generate
    if (WB_LATE_WRITE) begin : g_late
      assign take_wb = producer_hits(wb_dst, wb_wen, id_src);
      p_late_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_wen || wb_dst == '0) |-> !take_wb);
    end else begin : g_early
      logic unused_ok;
      assign unused_ok = ^{id_src, wb_dst, wb_wen};
      assign take_wb = 1'b0;
      p_early_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_wb);
    end
  endgenerate
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import hz_pkg::*;
#(
  parameter bit WB_LATE_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              stall_fetch,
  output logic              bubble_idex,
  output logic              id_a_take_wb,
  output logic              id_b_take_wb
);
  localparam int NUM_OPND = 2;

  reg_idx_t  ex_src [NUM_OPND];
  reg_idx_t  id_src [NUM_OPND];
  opnd_src_e opnd_sel [NUM_OPND];
  logic [NUM_OPND-1:0] mem_match, wb_match, id_take;

  assign ex_src[0] = ex_src_a;
  assign ex_src[1] = ex_src_b;
  assign id_src[0] = id_src_a;
  assign id_src[1] = id_src_b;

  generate
    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
      hz_operand_fwd u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (ex_src[k]),
        .mem_dst  (mem_dst),
        .mem_wen  (mem_wen),
        .wb_dst   (wb_dst),
        .wb_wen   (wb_wen),
        .sel      (opnd_sel[k]),
        .mem_match(mem_match[k]),
        .wb_match (wb_match[k])
      );
      hz_id_bypass #(.WB_LATE_WRITE(WB_LATE_WRITE)) u_idb (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_src (id_src[k]),
        .wb_dst (wb_dst),
        .wb_wen (wb_wen),
        .take_wb(id_take[k])
      );
    end
  endgenerate

  logic load_hold;
  hz_load_use u_ldu (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_in_ex(ex_is_load),
    .ld_dst  (ex_dst),
    .ld_wen  (ex_wen),
    .use_a   (id_src_a),
    .use_b   (id_src_b),
    .hold    (load_hold)
  );

  assign alu_a_sel    = opnd_sel[0];
  assign alu_b_sel    = opnd_sel[1];
  assign stall_fetch  = load_hold;
  assign bubble_idex  = load_hold;
  assign id_a_take_wb = id_take[0];
  assign id_b_take_wb = id_take[1];

  p_stall_bubble_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_fetch == bubble_idex);
  p_load_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_wen && ex_dst != '0 && ex_dst == id_src_a) |-> stall_fetch);
endmodule

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] ex_src_a, ex_src_b, ex_dst, id_src_a, id_src_b, mem_dst, wb_dst;
  logic ex_wen, ex_is_load, mem_wen, wb_wen;

  logic [1:0] e_a, e_b, l_a, l_b;
  logic e_st, e_bu, e_ia, e_ib, l_st, l_bu, l_ia, l_ib;

  fwd_hazard_unit #(.WB_LATE_WRITE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .alu_a_sel(e_a), .alu_b_sel(e_b),
    .stall_fetch(e_st), .bubble_idex(e_bu), .id_a_take_wb(e_ia), .id_b_take_wb(e_ib));

  fwd_hazard_unit #(.WB_LATE_WRITE(1'b1)) dut_late (
    .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .alu_a_sel(l_a), .alu_b_sel(l_b),
    .stall_fetch(l_st), .bubble_idex(l_bu), .id_a_take_wb(l_ia), .id_b_take_wb(l_ib));

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: 2 = memory stage, 1 = write-back, 0 = file.
  function automatic int ref_sel(input int src);
    int from_mem, from_wb;
    from_mem = (mem_wen && int'(mem_dst) == src && src != 0) ? 1 : 0;
    from_wb  = (wb_wen && int'(wb_dst) == src && src != 0) ? 1 : 0;
    if (from_mem == 1) return 2;
    if (from_wb == 1) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input int src);
    int m, w;
    m = (mem_wen && int'(mem_dst) == src && src != 0) ? 1 : 0;
    w = (wb_wen && int'(wb_dst) == src && src != 0) ? 1 : 0;
    if (m == 1 && w == 1) return "R3";
    if (m == 1) return "R1";
    if (w == 1) return "R2";
    return "R4";
  endfunction

  function automatic int ref_stall();
    if (!ex_is_load || !ex_wen || ex_dst == 0) return 0;
    if (ex_dst == id_src_a || ex_dst == id_src_b) return 1;
    return 0;
  endfunction

  function automatic int ref_late(input int src);
    return (wb_wen && src != 0 && int'(wb_dst) == src) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int st;
    st = ref_stall();
    chk(sel_tag(int'(ex_src_a)), int'(e_a), ref_sel(int'(ex_src_a)));
    chk(sel_tag(int'(ex_src_b)), int'(e_b), ref_sel(int'(ex_src_b)));
    chk(sel_tag(int'(ex_src_a)), int'(l_a), ref_sel(int'(ex_src_a)));
    chk(sel_tag(int'(ex_src_b)), int'(l_b), ref_sel(int'(ex_src_b)));
    chk("R9", (e_a == 2'b11 || e_b == 2'b11) ? 1 : 0, 0);
    chk("R5", int'(e_st), st);
    chk("R5", int'(l_st), st);
    chk("R6", int'(e_bu), st);
    chk("R6", int'(l_bu), st);
    chk("R7", int'(e_ia) + int'(e_ib), 0);
    chk("R8", int'(l_ia), ref_late(int'(id_src_a)));
    chk("R8", int'(l_ib), ref_late(int'(id_src_b)));
  endtask

  task automatic drive(input int xa, xb, xd, xw, xl, ia, ib, md, mw, wd, ww);
    @(negedge clk);
    ex_src_a = AW'(xa); ex_src_b = AW'(xb); ex_dst = AW'(xd);
    ex_wen = xw[0]; ex_is_load = xl[0];
    id_src_a = AW'(ia); id_src_b = AW'(ib);
    mem_dst = AW'(md); mem_wen = mw[0]; wb_dst = AW'(wd); wb_wen = ww[0];
    #1;
    compare_all();
  endtask

  initial begin
    #40000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // reset state: nothing forwarded, no stall
    chk("R4", int'(e_a) + int'(e_b) + int'(e_st), 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: memory-stage producer feeds operand a
    drive(3, 4, 0, 0, 0, 0, 0, 3, 1, 0, 0);
    chk("R1", int'(e_a), 2);
    // R2: write-back producer feeds operand b
    drive(3, 4, 0, 0, 0, 0, 0, 0, 0, 4, 1);
    chk("R2", int'(e_b), 1);
    // R3: both latches match, younger wins
    drive(5, 5, 0, 0, 0, 0, 0, 5, 1, 5, 1);
    chk("R3", int'(e_a), 2);
    // R4: register 0 and disabled producers
    drive(0, 6, 0, 0, 0, 0, 0, 0, 1, 6, 0);
    chk("R4", int'(e_a) + int'(e_b), 0);
    // R5: load-use on second decode source, with forwarding in the same cycle
    drive(2, 7, 9, 1, 1, 1, 9, 2, 1, 7, 1);
    chk("R5", int'(e_st), 1);
    chk("R6", int'(e_bu), 1);
    // R5: load to r0 never stalls; non-load producer never stalls
    drive(1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R5", int'(e_st), 0);
    drive(1, 1, 8, 1, 0, 8, 8, 0, 0, 0, 0);
    chk("R5", int'(e_st), 0);
    // R8: late-write decode bypass together with a stall
    drive(0, 0, 3, 1, 1, 3, 6, 0, 0, 6, 1);
    chk("R8", int'(l_ib), 1);
    chk("R7", int'(e_ib), 0);
    // pseudo-random with a small register space to force collisions
    for (int i = 0; i < 600; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule